// File: doc/BRIEF.md
# Dual-Lane Issue Pairing Unit

This block sits between a thread's decoded-instruction queue and a core that has two execution lanes. The resource lane runs IO operations and general arithmetic. The memory lane runs loads, stores, branches and general arithmetic. Each cycle the block looks at the two oldest queue entries, the older and the younger. It reads each entry's class and length and decides one of three things: issue nothing, issue the older entry alone, or issue both together. It also decides which lane each issued entry goes to. A long (32-bit) instruction occupies both lanes. A short (16-bit) instruction occupies one lane.

The queue side works as a stream. The two head entries are offered with valid flags, and `adv_cnt` acts as the ready response: it is combinational and tells the queue how many head entries were taken at this clock edge (0, 1 or 2). Back-pressure comes in through `stall`. While `stall` is high the block takes nothing and the queue must hold its head entries unchanged. The lane assignment is registered into the issue stage and is visible one cycle after the decision. A registered lane-valid flag of 0 is a bubble.

Class codes used on all class inputs: 0 = arithmetic, 1 = IO, 2 = load/store, 3 = branch. A slot code of 0 names the older entry and 1 names the younger.

Top module: `issue_pair_unit`

## Requirements
- R1: When `stall` is high or the older entry is not valid, `adv_cnt` is 0, and in the next cycle both lane-valid flags are 0. Both flags are 0 after reset.
- R2: A valid long older entry gives `adv_cnt` = 1. In the next cycle both lanes are valid, both slot codes are 0 and `wide_op` is 1.
- R3: When `dual_en` is 0, `adv_cnt` never exceeds 1.
- R4: An older entry issued alone goes to the resource lane when its class is IO (1). Otherwise (arithmetic, load/store, branch) it goes to the memory lane.
- R5: A short IO entry and a short load/store or branch entry pair in either age order, with `adv_cnt` = 2. The IO entry takes the resource lane and the other takes the memory lane.
- R6: When exactly one entry of a short pair is arithmetic (0), the pair issues, and the arithmetic entry takes the lane that the other entry does not need.
- R7: When both short entries are arithmetic, they pair. The older one takes the memory lane (mem slot 0) and the younger the resource lane (res slot 1).
- R8: Two short entries that both need the same fixed lane (both IO, or any mix of classes 2 and 3) never pair. The older one issues alone.
- R9: A long younger entry is never paired. The older one issues alone.
- R10: When the older entry writes a register (`old_wen`) that the younger one reads through an enabled source port, they do not pair. A matching index on a disabled port or without `old_wen` does not block pairing.
- R11: The younger entry is never issued unless the older one issues in the same cycle in the other lane. Both lanes never carry slot 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_en | input | 1 | Allows two entries to issue per cycle |
| stall | input | 1 | Back-pressure: take nothing this cycle |
| old_vld | input | 1 | Older head entry present |
| old_cls | input | 2 | Older entry class code |
| old_long | input | 1 | Older entry is 32-bit |
| old_wen | input | 1 | Older entry writes a register |
| old_dst | input | REG_W | Older entry destination index |
| yng_vld | input | 1 | Younger head entry present |
| yng_cls | input | 2 | Younger entry class code |
| yng_long | input | 1 | Younger entry is 32-bit |
| yng_rd_en | input | NSRC | Younger entry source-port enables |
| yng_rd_idx | input | NSRC*REG_W | Younger entry source indices, port 0 in the low bits |
| adv_cnt | output | 2 | Entries taken from the queue this edge |
| res_vld | output | 1 | Resource lane holds an instruction |
| res_slot | output | 1 | Which entry is in the resource lane |
| mem_vld | output | 1 | Memory lane holds an instruction |
| mem_slot | output | 1 | Which entry is in the memory lane |
| wide_op | output | 1 | One long instruction spans both lanes |

## Verification
On every cycle the assertions check the rules that need no knowledge of what is in the queue: a stall produces no take and a bubble afterwards, a disabled dual mode never takes two, a long entry fills both lanes with the older slot, a long younger entry never pairs, and the younger never issues in front of the older. Which lane a given class pair ends up in, the preference for the memory lane when both entries are arithmetic, and the register-hazard split can only be shown by the bench's sweep. That sweep covers every class, length, mode and hazard combination of the two head entries.

// File: rtl/issue_pkg.sv
package issue_pkg;
  typedef enum logic [1:0] {
    CLS_ARITH  = 2'd0,
    CLS_IO     = 2'd1,
    CLS_LDST   = 2'd2,
    CLS_BRANCH = 2'd3
  } insn_cls_e;

  // lane capability mask: bit 0 = resource lane, bit 1 = memory lane
  typedef struct packed {
    logic mem_ok;
    logic res_ok;
  } lane_mask_t;

  localparam logic SLOT_OLD = 1'b0;
  localparam logic SLOT_YNG = 1'b1;
endpackage

// File: rtl/lane_need.sv
module lane_need
  import issue_pkg::*;
(
  input  logic [1:0] cls,
  output lane_mask_t mask
);
  always_comb begin
    unique case (insn_cls_e'(cls))
      CLS_ARITH:  mask = '{mem_ok: 1'b1, res_ok: 1'b1};
      CLS_IO:     mask = '{mem_ok: 1'b0, res_ok: 1'b1};
      default:    mask = '{mem_ok: 1'b1, res_ok: 1'b0};
    endcase
  end
endmodule

// File: rtl/raw_hazard.sv
module raw_hazard #(
  parameter int REG_W = 4,
  parameter int NSRC  = 2
) (
  input  logic                       wr_en,
  input  logic [REG_W-1:0]           wr_idx,
  input  logic [NSRC-1:0]            rd_en,
  input  logic [NSRC-1:0][REG_W-1:0] rd_idx,
  output logic                       hit
);
  logic [NSRC-1:0] port_hit;

  for (genvar p = 0; p < NSRC; p++) begin : g_port
    assign port_hit[p] = rd_en[p] && (rd_idx[p] == wr_idx);
  end

  assign hit = wr_en && (|port_hit);
endmodule

// File: rtl/pair_decide.sv
module pair_decide
  import issue_pkg::*;
(
  input  logic       dual_en,
  input  logic       stall,
  input  logic       old_vld,
  input  logic       old_long,
  input  lane_mask_t old_mask,
  input  logic       yng_vld,
  input  logic       yng_long,
  input  lane_mask_t yng_mask,
  input  logic       hazard,
  output logic [1:0] adv,
  output logic       res_take,
  output logic       res_sel,
  output logic       mem_take,
  output logic       mem_sel,
  output logic       wide
);
  logic go;
  logic old_mem_yng_res;
  logic old_res_yng_mem;
  logic can_pair;

  assign go              = old_vld && !stall;
  assign old_mem_yng_res = old_mask.mem_ok && yng_mask.res_ok;
  assign old_res_yng_mem = old_mask.res_ok && yng_mask.mem_ok;
  assign can_pair        = dual_en && yng_vld && !yng_long && !hazard
                           && (old_mem_yng_res || old_res_yng_mem);

  always_comb begin
    adv      = 2'd0;
    res_take = 1'b0;
    mem_take = 1'b0;
    res_sel  = SLOT_OLD;
    mem_sel  = SLOT_OLD;
    wide     = 1'b0;
    if (go) begin
      if (old_long) begin
        adv      = 2'd1;
        res_take = 1'b1;
        mem_take = 1'b1;
        wide     = 1'b1;
      end else if (can_pair) begin
        adv      = 2'd2;
        res_take = 1'b1;
        mem_take = 1'b1;
        if (old_mem_yng_res) begin
          res_sel = SLOT_YNG;
        end else begin
          mem_sel = SLOT_YNG;
        end
      end else begin
        adv = 2'd1;
        if (old_mask.mem_ok) begin
          mem_take = 1'b1;
        end else begin
          res_take = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/issue_pair_unit.sv
module issue_pair_unit
  import issue_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int NSRC  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dual_en,
  input  logic                    stall,
  input  logic                    old_vld,
  input  logic [1:0]              old_cls,
  input  logic                    old_long,
  input  logic                    old_wen,
  input  logic [REG_W-1:0]        old_dst,
  input  logic                    yng_vld,
  input  logic [1:0]              yng_cls,
  input  logic                    yng_long,
  input  logic [NSRC-1:0]         yng_rd_en,
  input  logic [NSRC*REG_W-1:0]   yng_rd_idx,
  output logic [1:0]              adv_cnt,
  output logic                    res_vld,
  output logic                    res_slot,
  output logic                    mem_vld,
  output logic                    mem_slot,
  output logic                    wide_op
);
  localparam int NSLOT = 2;

  logic [NSLOT-1:0][1:0]    slot_cls;
  lane_mask_t [NSLOT-1:0]   slot_mask;
  logic [NSRC-1:0][REG_W-1:0] src_idx;
  logic hazard;
  logic res_take_d, res_sel_d, mem_take_d, mem_sel_d, wide_d;

  assign slot_cls[0] = old_cls;
  assign slot_cls[1] = yng_cls;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    lane_need u_need (
      .cls  (slot_cls[s]),
      .mask (slot_mask[s])
    );
  end

  for (genvar p = 0; p < NSRC; p++) begin : g_src
    assign src_idx[p] = yng_rd_idx[p*REG_W +: REG_W];
  end

  raw_hazard #(.REG_W(REG_W), .NSRC(NSRC)) u_haz (
    .wr_en  (old_wen),
    .wr_idx (old_dst),
    .rd_en  (yng_rd_en),
    .rd_idx (src_idx),
    .hit    (hazard)
  );

  pair_decide u_dec (
    .dual_en  (dual_en),
    .stall    (stall),
    .old_vld  (old_vld),
    .old_long (old_long),
    .old_mask (slot_mask[0]),
    .yng_vld  (yng_vld),
    .yng_long (yng_long),
    .yng_mask (slot_mask[1]),
    .hazard   (hazard),
    .adv      (adv_cnt),
    .res_take (res_take_d),
    .res_sel  (res_sel_d),
    .mem_take (mem_take_d),
    .mem_sel  (mem_sel_d),
    .wide     (wide_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_slot <= SLOT_OLD;
      mem_vld  <= 1'b0;
      mem_slot <= SLOT_OLD;
      wide_op  <= 1'b0;
    end else begin
      res_vld  <= res_take_d;
      res_slot <= res_sel_d;
      mem_vld  <= mem_take_d;
      mem_slot <= mem_sel_d;
      wide_op  <= wide_d;
    end
  end
endmodule

// File: rtl/issue_pair_chk.sv
module issue_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dual_en,
  input logic       stall,
  input logic       old_vld,
  input logic       old_long,
  input logic       yng_long,
  input logic [1:0] adv_cnt,
  input logic       res_vld,
  input logic       res_slot,
  input logic       mem_vld,
  input logic       mem_slot,
  input logic       wide_op
);
  // R1
  stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || !old_vld) |-> (adv_cnt == 2'd0));

  // R1
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || !old_vld) |=> (!res_vld && !mem_vld));

  // R2
  wide_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (old_vld && !stall && old_long) |=> (wide_op && res_vld && mem_vld && !res_slot && !mem_slot));

  // R3
  single_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_en |-> (adv_cnt <= 2'd1));

  // R9
  long_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yng_long |-> (adv_cnt != 2'd2));

  // R11
  order_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_slot) |-> (mem_vld && !mem_slot));

  // R11
  order_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vld && mem_slot) |-> (res_vld && !res_slot));

  // R11
  pair_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_cnt == 2'd2) |=> (res_vld && mem_vld && (res_slot != mem_slot) && !wide_op));
endmodule

bind issue_pair_unit issue_pair_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dual_en  (dual_en),
  .stall    (stall),
  .old_vld  (old_vld),
  .old_long (old_long),
  .yng_long (yng_long),
  .adv_cnt  (adv_cnt),
  .res_vld  (res_vld),
  .res_slot (res_slot),
  .mem_vld  (mem_vld),
  .mem_slot (mem_slot),
  .wide_op  (wide_op)
);

// File: tb/issue_pair_unit_tb.sv
module issue_pair_unit_tb_top;
  localparam int REG_W = 4;
  localparam int NSRC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual_en = 1'b0, stall = 1'b0;
  logic old_vld = 1'b0, old_long = 1'b0, old_wen = 1'b0;
  logic [1:0] old_cls = 2'd0, yng_cls = 2'd0;
  logic [REG_W-1:0] old_dst = '0;
  logic yng_vld = 1'b0, yng_long = 1'b0;
  logic [NSRC-1:0] yng_rd_en = '0;
  logic [NSRC*REG_W-1:0] yng_rd_idx = '0;
  logic [1:0] adv_cnt;
  logic res_vld, res_slot, mem_vld, mem_slot, wide_op;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  issue_pair_unit #(.REG_W(REG_W), .NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .dual_en(dual_en), .stall(stall),
    .old_vld(old_vld), .old_cls(old_cls), .old_long(old_long),
    .old_wen(old_wen), .old_dst(old_dst),
    .yng_vld(yng_vld), .yng_cls(yng_cls), .yng_long(yng_long),
    .yng_rd_en(yng_rd_en), .yng_rd_idx(yng_rd_idx),
    .adv_cnt(adv_cnt), .res_vld(res_vld), .res_slot(res_slot),
    .mem_vld(mem_vld), .mem_slot(mem_slot), .wide_op(wide_op)
  );

  // fixed lane of a non-arithmetic class: 0 = resource, 1 = memory
  function automatic int home_lane(input int c);
    return (c == 1) ? 0 : 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    int e_adv, e_rv, e_rs, e_mv, e_ms, e_w;
    bit haz, pair;
    string tag;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset lanes", {res_vld, mem_vld, wide_op}, 0);
    rst_n = 1'b1;
    for (int s0 = 0; s0 < 2; s0++)
    for (int s1 = 0; s1 < 2; s1++)
    for (int st = 0; st < 2; st++)
    for (int du = 0; du < 2; du++)
    for (int c0 = 0; c0 < 4; c0++)
    for (int l0 = 0; l0 < 2; l0++)
    for (int c1 = 0; c1 < 4; c1++)
    for (int l1 = 0; l1 < 2; l1++)
    for (int hz = 0; hz < 5; hz++) begin
      @(negedge clk);
      old_vld = s0[0]; yng_vld = s1[0]; stall = st[0]; dual_en = du[0];
      old_cls = c0[1:0]; old_long = l0[0]; yng_cls = c1[1:0]; yng_long = l1[0];
      old_dst = 4'd3; old_wen = (hz != 3);
      yng_rd_en = 2'b11; yng_rd_idx = {4'd6, 4'd5};
      case (hz)
        1: yng_rd_idx = {4'd6, 4'd3};
        2: yng_rd_idx = {4'd3, 4'd5};
        3: yng_rd_idx = {4'd6, 4'd3};
        4: begin yng_rd_idx = {4'd6, 4'd3}; yng_rd_en = 2'b10; end
        default: ;
      endcase
      haz = (hz == 1) || (hz == 2);
      // expected outcome
      e_adv = 0; e_rv = 0; e_rs = 0; e_mv = 0; e_ms = 0; e_w = 0;
      if (s0 == 0 || st == 1) begin
        tag = "R1";
      end else if (l0 == 1) begin
        tag = "R2"; e_adv = 1; e_rv = 1; e_mv = 1; e_w = 1;
      end else begin
        pair = 1'b1;
        if (c0 != 0 && c1 != 0 && home_lane(c0) == home_lane(c1)) pair = 1'b0;
        if (du == 0)      begin pair = 1'b0; tag = "R3"; end
        else if (s1 == 0) begin pair = 1'b0; tag = "R4"; end
        else if (l1 == 1) begin pair = 1'b0; tag = "R9"; end
        else if (haz)     begin pair = 1'b0; tag = "R10"; end
        else if (!pair)   tag = "R8";
        else if (c0 == 0 && c1 == 0) tag = "R7";
        else if (c0 == 0 || c1 == 0) tag = "R6";
        else tag = "R5";
        if (pair) begin
          int old_lane;
          e_adv = 2; e_rv = 1; e_mv = 1;
          if (c0 == 0 && c1 == 0) old_lane = 1;
          else if (c0 == 0) old_lane = 1 - home_lane(c1);
          else old_lane = home_lane(c0);
          if (old_lane == 1) e_rs = 1; else e_ms = 1;
        end else begin
          e_adv = 1;
          if (c0 == 1) e_rv = 1; else e_mv = 1;
          if (tag == "R3" || tag == "R9" || tag == "R10" || tag == "R8") ;
          else tag = "R4";
        end
      end
      #1;
      check({tag, " adv"}, adv_cnt, e_adv);
      @(posedge clk);
      #1;
      check({tag, " lanes"}, {res_vld, res_slot, mem_vld, mem_slot, wide_op},
            {e_rv[0], e_rs[0], e_mv[0], e_ms[0], e_w[0]});
      // R11 younger never without older in the other lane
      check("R11 order",
            int'((res_vld && res_slot && !(mem_vld && !mem_slot)) ||
                 (mem_vld && mem_slot && !(res_vld && !res_slot))), 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule